// File: doc/BRIEF.md
# Reference-Timed Phase/Frequency Detector with Lock Control

This block is the fast-acquisition half of a radio tuning synthesizer loop. The system clock is the crystal clock. It is divided down to a comparison rate, either every 125 or every 100 crystal cycles, and that rate is divided by 32 again to give the slow-comparison strobe. A divided-oscillator pulse comes in from outside. A three-state detector compares it with the reference tick and drives pump-up and pump-down enables, whose width is the phase error in crystal cycles.

A lock counter judges every finished comparison. A run of eight close comparisons declares lock. Any wide comparison, or a slip, clears the counter at once. In automatic mode the detector outputs are muted while the loop is locked, so that the slow detector can take over. Two mode bits can instead hold the detector on or off. The lock judgement runs in every mode.

Top module: `pll_pd_top`

## Requirements
- R1: With ref_sel_i=0 the ref_tick_o output is a one-cycle pulse every 125 clock cycles. With ref_sel_i=1 the pulse comes every 100 cycles.
- R2: slow_tick_o pulses on every 32nd ref_tick_o, and only in a cycle where ref_tick_o is also high.
- R3: When vco_pulse_i arrives d cycles after a ref_tick_o cycle (d ≥ 1) and the detector is enabled, up_o is high for exactly d consecutive cycles, starting in the cycle after the tick.
- R4: When vco_pulse_i arrives d cycles before a ref_tick_o cycle and the detector is enabled, dn_o is high for exactly d consecutive cycles, ending in the tick cycle.
- R5: A vco pulse in the same cycle as the reference tick produces no pump output. up_o and dn_o are never high together.
- R6: A comparison whose error is 0 or 1 cycles counts as good. lock_o becomes 1 in the cycle after the 8th consecutive good comparison, and not earlier. An error of 2 cycles is not good.
- R7: A comparison with an error of 2 or more cycles clears the lock count, so lock_o is 0 in the next cycle. A slip has the same effect. A slip is a second reference tick before the vco pulse, or a second vco pulse before the tick.
- R8: The mode_i encodings are: 2'b00 or 2'b01 automatic, with det_en_o = !lock_o; 2'b10 forced on, det_en_o=1; 2'b11 forced off, det_en_o=0. up_o and dn_o are gated by det_en_o. lock_o is evaluated in every mode.
- R9: While rst_ni is low, up_o, dn_o, lock_o and ref_tick_o are 0, and det_en_o is 1 in automatic mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_sel_i | input | 1 | 0: divide by 125, 1: divide by 100 |
| mode_i | input | 2 | Detector mode (auto / forced on / forced off) |
| vco_pulse_i | input | 1 | One-cycle divided oscillator pulse |
| ref_tick_o | output | 1 | Comparison-rate reference tick |
| slow_tick_o | output | 1 | Reference tick divided by 32 |
| up_o | output | 1 | Pump-up enable |
| dn_o | output | 1 | Pump-down enable |
| det_en_o | output | 1 | Detector outputs enabled |
| lock_o | output | 1 | 1 = in lock, 0 = out of lock |

## Verification
The assertions watch the cycle-level invariants on every cycle. They check that up and down are exclusive, that the slow strobe falls on a reference tick, that the reference tick lasts one cycle, that the pump stays silent when forced off or when locked in automatic mode, and that a bad comparison drops lock and only a good one raises it. Only the bench scenarios can show the counted behaviours: the 125 and 100 cycle periods, the divide by 32, the exact pump pulse widths for leading and lagging oscillator pulses, and the eighth-comparison lock boundary with the one- and two-cycle error cases. The bench also shows that a slip in forced-off mode still clears lock.

// File: rtl/pll_pd_pkg.sv
package pll_pd_pkg;
  typedef enum logic [1:0] {
    MODE_AUTO_A = 2'b00,
    MODE_AUTO_B = 2'b01,
    MODE_ON     = 2'b10,
    MODE_OFF    = 2'b11
  } pd_mode_e;
endpackage

// File: rtl/pll_ref_div.sv
module pll_ref_div #(
  parameter int DIV_LO   = 125,
  parameter int DIV_HI   = 100,
  parameter int SLOW_DIV = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  output logic tick_o,
  output logic slow_o
);
  localparam int MAXDIV = (DIV_LO > DIV_HI) ? DIV_LO : DIV_HI;
  localparam int CW     = $clog2(MAXDIV);
  localparam int SW     = $clog2(SLOW_DIV);

  logic [CW-1:0] cnt_q, last;
  logic [SW-1:0] scnt_q;

  assign last   = sel_i ? CW'(DIV_HI - 1) : CW'(DIV_LO - 1);
  // >= keeps the counter bounded when the ratio shrinks mid-count
  assign tick_o = (cnt_q >= last);
  assign slow_o = tick_o && (scnt_q == SW'(SLOW_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      scnt_q <= '0;
    end else begin
      cnt_q <= tick_o ? '0 : cnt_q + CW'(1);
      if (tick_o) scnt_q <= slow_o ? '0 : scnt_q + SW'(1);
    end
  end

  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R1
endmodule

// File: rtl/pll_pfd_core.sv
module pll_pfd_core #(
  parameter int ERR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic             vco_i,
  output logic             up_o,
  output logic             dn_o,
  output logic             done_o,
  output logic             slip_o,
  output logic [ERR_W-1:0] err_o
);
  logic up_q, dn_q, up_n, dn_n, busy;
  logic [ERR_W-1:0] age_q;

  assign up_n   = up_q | ref_i;
  assign dn_n   = dn_q | vco_i;
  assign busy   = up_q | dn_q;
  assign done_o = up_n & dn_n;
  assign slip_o = (ref_i & up_q) | (vco_i & dn_q);
  assign err_o  = busy ? age_q : '0;
  assign up_o   = up_q;
  assign dn_o   = dn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      age_q <= '0;
    end else begin
      up_q <= up_n & ~done_o;
      dn_q <= dn_n & ~done_o;
      if (done_o || !(up_n || dn_n)) age_q <= '0;
      else if (!busy)                age_q <= ERR_W'(1);
      else if (age_q != '1)          age_q <= age_q + ERR_W'(1);
    end
  end

  AST_NO_BOTH_PUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_q && dn_q)); // R5
endmodule

// File: rtl/pll_lock_det.sv
module pll_lock_det #(
  parameter int LOCK_CNT = 8,
  parameter int LOCK_WIN = 2,
  parameter int ERR_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic             slip_i,
  input  logic [ERR_W-1:0] err_i,
  output logic             lock_o
);
  localparam int LW = $clog2(LOCK_CNT + 1);

  logic [LW-1:0] run_q;
  logic good, bad;

  assign good   = done_i && !slip_i && (err_i < ERR_W'(LOCK_WIN));
  assign bad    = slip_i || (done_i && (err_i >= ERR_W'(LOCK_WIN)));
  assign lock_o = (run_q == LW'(LOCK_CNT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  run_q <= '0;
    else if (bad)                 run_q <= '0;
    else if (good && !lock_o)     run_q <= run_q + LW'(1);
  end

  AST_BAD_DROPS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |=> !lock_o); // R7
  AST_LOCK_FROM_GOOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(good)); // R6
endmodule

// File: rtl/pll_pd_top.sv
module pll_pd_top
  import pll_pd_pkg::*;
#(
  parameter int XTAL_DIV_LO = 125,
  parameter int XTAL_DIV_HI = 100,
  parameter int SLOW_RATIO  = 32,
  parameter int LOCK_COUNT  = 8,
  parameter int LOCK_WINDOW = 2,
  parameter int ERR_W       = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_sel_i,
  input  logic [1:0] mode_i,
  input  logic       vco_pulse_i,
  output logic       ref_tick_o,
  output logic       slow_tick_o,
  output logic       up_o,
  output logic       dn_o,
  output logic       det_en_o,
  output logic       lock_o
);
  pd_mode_e         mode;
  logic             up_raw, dn_raw, done, slip, det_en;
  logic [ERR_W-1:0] err;

  assign mode = pd_mode_e'(mode_i);

  pll_ref_div #(.DIV_LO(XTAL_DIV_LO), .DIV_HI(XTAL_DIV_HI), .SLOW_DIV(SLOW_RATIO)) u_div (
    .clk_i, .rst_ni, .sel_i(ref_sel_i), .tick_o(ref_tick_o), .slow_o(slow_tick_o)
  );

  pll_pfd_core #(.ERR_W(ERR_W)) u_pfd (
    .clk_i, .rst_ni, .ref_i(ref_tick_o), .vco_i(vco_pulse_i),
    .up_o(up_raw), .dn_o(dn_raw), .done_o(done), .slip_o(slip), .err_o(err)
  );

  pll_lock_det #(.LOCK_CNT(LOCK_COUNT), .LOCK_WIN(LOCK_WINDOW), .ERR_W(ERR_W)) u_lock (
    .clk_i, .rst_ni, .done_i(done), .slip_i(slip), .err_i(err), .lock_o(lock_o)
  );

  always_comb begin
    unique case (mode)
      MODE_ON:  det_en = 1'b1;
      MODE_OFF: det_en = 1'b0;
      default:  det_en = ~lock_o;
    endcase
  end

  assign det_en_o = det_en;
  assign up_o     = up_raw & det_en;
  assign dn_o     = dn_raw & det_en;

  AST_SLOW_ON_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_tick_o |-> ref_tick_o); // R2
  AST_FORCED_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11) |-> (!up_o && !dn_o)); // R8
  AST_AUTO_LOCK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i[1] && lock_o) |-> (!up_o && !dn_o)); // R8
  AST_FORCED_ON_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10) |-> det_en_o); // R8
endmodule

// File: tb/pll_pd_top_tb_top.sv
module pll_pd_top_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, ref_sel = 1'b0, vco = 1'b0;
  logic [1:0] mode = 2'b00;
  logic ref_tick, slow_tick, up, dn, det_en, lock;

  pll_pd_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ref_sel_i(ref_sel), .mode_i(mode),
    .vco_pulse_i(vco), .ref_tick_o(ref_tick), .slow_tick_o(slow_tick),
    .up_o(up), .dn_o(dn), .det_en_o(det_en), .lock_o(lock)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc++;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { bit is_up; int width; } pulse_t;
  pulse_t exp_q[$];

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: pops an expected pulse at the end of each pump pulse
  int run_up = 0, run_dn = 0;
  int ticks_since = 0, slow_iv = 0, slow_seen = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      pulse_t p;
      if (up && dn) check(0, "R5", "up and dn together", 1, 0);
      if (!up && run_up > 0) begin
        if (exp_q.size() == 0) check(0, "R3", "unexpected up pulse", run_up, 0);
        else begin
          p = exp_q.pop_front();
          check(p.is_up && p.width == run_up, "R3", "up pulse width", run_up, p.is_up ? p.width : 0);
        end
        run_up = 0;
      end
      if (!dn && run_dn > 0) begin
        if (exp_q.size() == 0) check(0, "R4", "unexpected dn pulse", run_dn, 0);
        else begin
          p = exp_q.pop_front();
          check(!p.is_up && p.width == run_dn, "R4", "dn pulse width", run_dn, !p.is_up ? p.width : 0);
        end
        run_dn = 0;
      end
      if (up) run_up++;
      if (dn) run_dn++;
      if (ref_tick) ticks_since++;
      if (slow_tick) begin
        slow_iv = ticks_since;
        ticks_since = 0;
        slow_seen++;
      end
    end
  end

  int last_tick = 0, prev_tick = 0;

  task automatic wait_tick();
    do @(negedge clk); while (!ref_tick);
    prev_tick = last_tick;
    last_tick = cyc;
  endtask

  // driver: vco d cycles after the tick; pushes the expected up pulse
  task automatic lag(int d, bit exp_p);
    pulse_t p;
    wait_tick();
    if (d > 0) repeat (d) @(negedge clk);
    vco = 1'b1;
    if (exp_p && d > 0) begin p.is_up = 1; p.width = d; exp_q.push_back(p); end
    @(negedge clk);
    vco = 1'b0;
  endtask

  task automatic pairs(int n);
    repeat (n) lag(0, 0);
  endtask

  // in-phase comparison, then vco d cycles ahead of the next tick
  task automatic lead(int d, bit exp_p);
    pulse_t p;
    int per;
    per = ref_sel ? 100 : 125;
    lag(0, 0);
    repeat (per - d - 1) @(negedge clk);
    vco = 1'b1;
    if (exp_p) begin p.is_up = 0; p.width = d; exp_q.push_back(p); end
    @(negedge clk);
    vco = 1'b0;
    repeat (d) @(negedge clk);
  endtask

  task automatic skip();
    wait_tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!up && !dn, "R9", "pump idle in reset", {up, dn}, 0);
    check(!lock, "R9", "lock in reset", lock, 0);
    check(det_en, "R9", "det_en in reset", det_en, 1);
    check(!ref_tick, "R9", "ref_tick in reset", ref_tick, 0);
    rst_n = 1'b1;

    pairs(2);
    check(last_tick - prev_tick == 125, "R1", "period sel=0", last_tick - prev_tick, 125);
    lag(5, 1);
    check(!lock, "R7", "lock after 5-cycle lag", lock, 0);
    lead(4, 1);
    check(!lock, "R7", "lock after 4-cycle lead", lock, 0);
    lag(2, 1);
    check(!lock, "R6", "error of 2 not good", lock, 0);
    pairs(6);
    lag(1, 1);
    check(!lock, "R6", "no lock after 7 good", lock, 0);
    check(det_en, "R8", "auto enabled unlocked", det_en, 1);
    pairs(1);
    check(lock, "R6", "lock after 8 good", lock, 1);
    check(!det_en, "R8", "auto disabled locked", det_en, 0);
    lag(3, 0);
    check(!lock, "R7", "wide error drops lock", lock, 0);
    check(det_en, "R8", "auto re-enabled", det_en, 1);

    mode = 2'b10;
    pairs(8);
    check(lock, "R6", "lock in forced-on", lock, 1);
    check(det_en, "R8", "forced-on while locked", det_en, 1);
    lag(3, 1);
    check(!lock, "R7", "drop in forced-on", lock, 0);

    mode = 2'b11;
    @(negedge clk);
    check(!det_en, "R8", "forced-off det_en", det_en, 0);
    lag(3, 0);
    pairs(8);
    check(lock, "R8", "lock judged while forced off", lock, 1);
    skip();
    pairs(1);
    check(!lock, "R7", "slip drops lock", lock, 0);

    mode = 2'b00;
    pairs(8);
    check(lock && !det_en, "R8", "auto locked again", {lock, det_en}, 2);
    pairs(40);
    check(slow_seen >= 2, "R2", "slow ticks seen", slow_seen, 2);
    check(slow_iv == 32, "R2", "ref ticks per slow tick", slow_iv, 32);

    ref_sel = 1'b1;
    pairs(2);
    check(last_tick - prev_tick == 100, "R1", "period sel=1", last_tick - prev_tick, 100);
    lead(3, 0);
    check(!lock, "R7", "lead drops lock", lock, 0);
    lead(3, 1);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R3", "expected pulses left", exp_q.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule